// File: doc/BRIEF.md
# Processor Debug Command Port

This block is the front door through which an external debug host reaches a pipelined processor core. Every debug command is presented for one cycle and carries a valid flag, a write flag, a two-bit region code, a 12-bit register address and a data word. The block registers the command and steers it to one of three targets. These are the control/status register bank, the integer register bank (which also holds the next-PC register), or a small set of control registers kept inside the block. One cycle after the command it raises a ready flag and returns the read word.

The control registers let the host stop and restart the pipeline and choose how a breakpoint instruction behaves. They also expose two free-running 64-bit counters: clock cycles spent running and instructions retired. Finally, they arm a one-shot instruction substitution. The host plants a breakpoint in memory, records its address and the original instruction here, and the core's fetch stage takes the original word once, which disarms the record.

Top module: `dbg_access_port`

## Requirements
- R1: `resp_ready` is high in exactly the cycle after a cycle with `req_valid` high, and low in every other cycle.
- R2: Region code 0 selects the CSR bank. In the ready cycle `csr_en` is high, `csr_we` equals the command's write flag, and `bank_addr` and `bank_wdata` carry the command's address and data. `resp_rdata` returns `csr_rdata`.
- R3: Region code 1 selects the integer bank, and `ireg_en` is high in the ready cycle. Addresses 0 to 31 index a register through `ireg_idx` (the low 5 address bits), and a write pulses `ireg_we`. A write to address 32 pulses `npc_we` and leaves `ireg_we` low. `resp_rdata` returns `ireg_rdata`.
- R4: Region codes 2 and 3 drive neither bank enable. Region 3 returns zero on a read and changes no state.
- R5: In region 2, address 0 is the halt register. Writing 1 to bit 0 raises `halt_o` from the cycle after the ready cycle, writing 0 lowers it, and a read returns the current halt bit.
- R6: Region 2 address 2 reads a 64-bit clock counter. The counter advances by one on every clock edge where the core is not halted and holds its value while halted. Writes to it are ignored.
- R7: Region 2 address 3 reads a 64-bit counter of `retire_i` strobes. It adds one per clock with `retire_i` high, and writes to it are ignored.
- R8: Region 2 address 1 bit 0 is the break mode (0 = halt on breakpoint, 1 = trap). It drives `brk_mode` and reads back.
- R9: Region 2 address 4 holds the injection address and address 5 the original 32-bit instruction. A write to address 5 sets `inj_valid`. A clock with `inj_take` high clears `inj_valid`, and the address and instruction are left unchanged.
- R10: While `rst_n` is low, halt, break mode, both counters and `inj_valid` clear.
- R11: A region 2 read of an address outside 0 to 5 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Debug command present this cycle |
| req_write | input | 1 | Command is a write |
| req_region | input | 2 | Target region code |
| req_addr | input | 12 | Register address inside the region |
| req_wdata | input | DATA_W | Write data |
| resp_ready | output | 1 | Response valid (cycle after command) |
| resp_rdata | output | DATA_W | Read data returned with ready |
| csr_en | output | 1 | CSR bank access this cycle |
| csr_we | output | 1 | CSR bank write |
| bank_addr | output | 12 | Address forwarded to the banks |
| bank_wdata | output | DATA_W | Write data forwarded to the banks |
| csr_rdata | input | DATA_W | CSR bank debug read data |
| ireg_en | output | 1 | Integer bank access this cycle |
| ireg_we | output | 1 | Integer register write pulse |
| npc_we | output | 1 | Next-PC write pulse |
| ireg_idx | output | 5 | Integer register index |
| ireg_rdata | input | DATA_W | Integer bank debug read data |
| halt_o | output | 1 | Pipeline hold request |
| retire_i | input | 1 | Instruction retired strobe |
| brk_mode | output | 1 | Breakpoint response: 0 halt, 1 trap |
| inj_valid | output | 1 | Injection record armed |
| inj_addr | output | ADDR_W | Breakpoint address to substitute at |
| inj_instr | output | 32 | Original instruction to supply |
| inj_take | input | 1 | Fetch consumed the injected instruction |

## Verification
A wrong registered command shows at the ports in the ready cycle itself. It appears as a missing or doubled `resp_ready`, an enable on the wrong bank, a write pulse on a read, or the wrong read source, so each region is driven with both reads and writes and checked in that one cycle. A corrupted control register appears one cycle after its write, on `halt_o`, `brk_mode` or `inj_valid`. Counter faults cannot be seen directly. They surface through readback deltas, because the clock counter must advance by exactly the number of elapsed edges while running and by zero while halted.

// File: rtl/dap_pkg.sv
package dap_pkg;
    typedef enum logic [1:0] {
        RGN_CSR  = 2'd0,
        RGN_IREG = 2'd1,
        RGN_CTRL = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    localparam int REG_ADDR_W = 12;
    localparam int IDX_W      = 5;
    localparam int INSTR_W    = 32;

    // control region address map
    localparam logic [REG_ADDR_W-1:0] CA_HALT = 12'd0;
    localparam logic [REG_ADDR_W-1:0] CA_BRK  = 12'd1;
    localparam logic [REG_ADDR_W-1:0] CA_CLK  = 12'd2;
    localparam logic [REG_ADDR_W-1:0] CA_RET  = 12'd3;
    localparam logic [REG_ADDR_W-1:0] CA_INJA = 12'd4;
    localparam logic [REG_ADDR_W-1:0] CA_INJI = 12'd5;

    // integer region: address of the next-PC register
    localparam logic [REG_ADDR_W-1:0] IA_NPC  = 12'd32;
endpackage

// File: rtl/dap_cmd_stage.sv
module dap_cmd_stage
    import dap_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_region,
    input  logic [REG_ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  pend_vld,
    output region_e               pend_rgn,
    output logic [REG_ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0]     pend_data,
    output logic                  csr_en,
    output logic                  csr_we,
    output logic                  ireg_en,
    output logic                  ireg_we,
    output logic                  npc_we,
    output logic                  ctrl_we
);
    typedef struct packed {
        logic                  vld;
        logic                  wr;
        region_e               rgn;
        logic [REG_ADDR_W-1:0] addr;
        logic [DATA_W-1:0]     data;
    } cmd_t;

    cmd_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.wr   = req_write;
            st_d.rgn  = region_e'(req_region);
            st_d.addr = req_addr;
            st_d.data = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic reg_slot;
    assign reg_slot  = (st_q.addr[REG_ADDR_W-1:IDX_W] == '0);

    assign pend_vld  = st_q.vld;
    assign pend_rgn  = st_q.rgn;
    assign pend_addr = st_q.addr;
    assign pend_data = st_q.data;
    assign csr_en    = st_q.vld && (st_q.rgn == RGN_CSR);
    assign csr_we    = csr_en && st_q.wr;
    assign ireg_en   = st_q.vld && (st_q.rgn == RGN_IREG);
    assign ireg_we   = ireg_en && st_q.wr && reg_slot;
    assign npc_we    = ireg_en && st_q.wr && (st_q.addr == IA_NPC);
    assign ctrl_we   = st_q.vld && st_q.wr && (st_q.rgn == RGN_CTRL);

    // R1
    ready_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pend_vld);
    // R1
    no_spurious_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !pend_vld);
    // R4
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({csr_en, ireg_en, ctrl_we}));
    // R2
    csr_we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |-> csr_en);
    // R3
    ireg_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ireg_we && npc_we));
endmodule

// File: rtl/dap_counters.sv
module dap_counters #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             retire,
    output logic [CNT_W-1:0] clk_cnt,
    output logic [CNT_W-1:0] ret_cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] ret;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!halt)  cnt_d.run = cnt_q.run + 1'b1;
        if (retire) cnt_d.ret = cnt_q.ret + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign clk_cnt = cnt_q.run;
    assign ret_cnt = cnt_q.ret;

    // R6
    halted_clock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(clk_cnt));
    // R7
    idle_retire_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(ret_cnt));
endmodule

// File: rtl/dap_ctrl_regs.sv
module dap_ctrl_regs
    import dap_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  inj_take,
    output logic                  halt,
    output logic                  brk_mode,
    output logic                  inj_valid,
    output logic [ADDR_W-1:0]     inj_addr,
    output logic [INSTR_W-1:0]    inj_instr
);
    typedef struct packed {
        logic               halt;
        logic               brk;
        logic               inj_v;
        logic [ADDR_W-1:0]  inj_a;
        logic [INSTR_W-1:0] inj_i;
    } ctrl_t;

    ctrl_t cr_d, cr_q;
    logic  arm_inj;

    assign arm_inj = wr_en && (addr == CA_INJI);

    always_comb begin
        cr_d = cr_q;
        if (inj_take) cr_d.inj_v = 1'b0;
        if (wr_en) begin
            case (addr)
                CA_HALT: cr_d.halt  = wdata[0];
                CA_BRK:  cr_d.brk   = wdata[0];
                CA_INJA: cr_d.inj_a = wdata[ADDR_W-1:0];
                CA_INJI: begin
                    cr_d.inj_i = wdata[INSTR_W-1:0];
                    cr_d.inj_v = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:1];

    assign halt      = cr_q.halt;
    assign brk_mode  = cr_q.brk;
    assign inj_valid = cr_q.inj_v;
    assign inj_addr  = cr_q.inj_a;
    assign inj_instr = cr_q.inj_i;

    // R9
    inj_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_take && !arm_inj) |=> !inj_valid);
    // R9
    inj_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_inj |=> inj_valid);
    // R8
    brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(brk_mode));
    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(halt));
endmodule

// File: rtl/dbg_access_port.sv
module dbg_access_port
    import dap_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_region,
    input  logic [11:0]           req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  resp_ready,
    output logic [DATA_W-1:0]     resp_rdata,
    output logic                  csr_en,
    output logic                  csr_we,
    output logic [11:0]           bank_addr,
    output logic [DATA_W-1:0]     bank_wdata,
    input  logic [DATA_W-1:0]     csr_rdata,
    output logic                  ireg_en,
    output logic                  ireg_we,
    output logic                  npc_we,
    output logic [4:0]            ireg_idx,
    input  logic [DATA_W-1:0]     ireg_rdata,
    output logic                  halt_o,
    input  logic                  retire_i,
    output logic                  brk_mode,
    output logic                  inj_valid,
    output logic [ADDR_W-1:0]     inj_addr,
    output logic [31:0]           inj_instr,
    input  logic                  inj_take
);
    logic                  pend_vld;
    region_e               pend_rgn;
    logic [REG_ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0]     pend_data;
    logic                  ctrl_we;
    logic [CNT_W-1:0]      clk_cnt;
    logic [CNT_W-1:0]      ret_cnt;
    logic [DATA_W-1:0]     ctrl_rd;

    dap_cmd_stage #(.DATA_W(DATA_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_region (req_region),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .pend_vld   (pend_vld),
        .pend_rgn   (pend_rgn),
        .pend_addr  (pend_addr),
        .pend_data  (pend_data),
        .csr_en     (csr_en),
        .csr_we     (csr_we),
        .ireg_en    (ireg_en),
        .ireg_we    (ireg_we),
        .npc_we     (npc_we),
        .ctrl_we    (ctrl_we)
    );

    dap_ctrl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_we),
        .addr      (pend_addr),
        .wdata     (pend_data),
        .inj_take  (inj_take),
        .halt      (halt_o),
        .brk_mode  (brk_mode),
        .inj_valid (inj_valid),
        .inj_addr  (inj_addr),
        .inj_instr (inj_instr)
    );

    dap_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (halt_o),
        .retire  (retire_i),
        .clk_cnt (clk_cnt),
        .ret_cnt (ret_cnt)
    );

    always_comb begin
        case (pend_addr)
            CA_HALT: ctrl_rd = DATA_W'(halt_o);
            CA_BRK:  ctrl_rd = DATA_W'(brk_mode);
            CA_CLK:  ctrl_rd = DATA_W'(clk_cnt);
            CA_RET:  ctrl_rd = DATA_W'(ret_cnt);
            CA_INJA: ctrl_rd = DATA_W'(inj_addr);
            CA_INJI: ctrl_rd = DATA_W'(inj_instr);
            default: ctrl_rd = '0;
        endcase
    end

    always_comb begin
        resp_rdata = '0;
        if (pend_vld) begin
            case (pend_rgn)
                RGN_CSR:  resp_rdata = csr_rdata;
                RGN_IREG: resp_rdata = ireg_rdata;
                RGN_CTRL: resp_rdata = ctrl_rd;
                default:  resp_rdata = '0;
            endcase
        end
    end

    assign resp_ready = pend_vld;
    assign bank_addr  = pend_addr;
    assign bank_wdata = pend_data;
    assign ireg_idx   = pend_addr[IDX_W-1:0];

    // R4
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_ready |-> (resp_rdata == '0));
endmodule

// File: tb/sim_dbg_access_port.sv
module sim_dbg_access_port;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_region = '0;
    logic [11:0]   req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          resp_ready;
    logic [DW-1:0] resp_rdata;
    logic          csr_en, csr_we, ireg_en, ireg_we, npc_we;
    logic [11:0]   bank_addr;
    logic [DW-1:0] bank_wdata, csr_rdata, ireg_rdata;
    logic [4:0]    ireg_idx;
    logic          halt_o, brk_mode, inj_valid;
    logic          retire_i = 1'b0, inj_take = 1'b0;
    logic [AW-1:0] inj_addr;
    logic [31:0]   inj_instr;

    int checks = 0, fails = 0;
    longint unsigned cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // bank stubs: read data derived from the forwarded address
    assign csr_rdata  = 64'hC5C5_0000_0000_0000 | DW'(bank_addr);
    assign ireg_rdata = 64'h1E60_0000_0000_0000 | DW'(ireg_idx);

    dbg_access_port u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_region(req_region), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_ready(resp_ready), .resp_rdata(resp_rdata), .csr_en(csr_en),
        .csr_we(csr_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
        .csr_rdata(csr_rdata), .ireg_en(ireg_en), .ireg_we(ireg_we),
        .npc_we(npc_we), .ireg_idx(ireg_idx), .ireg_rdata(ireg_rdata),
        .halt_o(halt_o), .retire_i(retire_i), .brk_mode(brk_mode),
        .inj_valid(inj_valid), .inj_addr(inj_addr), .inj_instr(inj_instr),
        .inj_take(inj_take)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive a command at a falling edge; return at the falling edge of the ready cycle
    task automatic issue(input logic wr, input logic [1:0] rgn, input logic [11:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_write = wr; req_region = rgn; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_ctrl(input logic [11:0] a, output logic [63:0] v, output longint unsigned at);
        issue(1'b0, 2'd2, a, '0);
        v = resp_rdata;
        at = cyc;
    endtask

    task automatic t_reset();
        logic [63:0] v; longint unsigned t;
        chk(resp_ready == 0, "R1 idle ready", 64'(resp_ready), 0);
        chk(halt_o == 0 && brk_mode == 0 && inj_valid == 0, "R10 reset flags",
            {61'd0, halt_o, brk_mode, inj_valid}, 0);
        rd_ctrl(12'd3, v, t);
        chk(v == 0, "R10 retire count reset", v, 0);
    endtask

    task automatic t_csr();
        issue(1'b1, 2'd0, 12'h305, 64'hDEAD_0000_1234_5678);
        chk(resp_ready == 1, "R1 ready after csr write", 64'(resp_ready), 1);
        chk(csr_en && csr_we && !ireg_en, "R2 csr write enables",
            {61'd0, csr_en, csr_we, ireg_en}, 64'h6);
        chk(bank_addr == 12'h305 && bank_wdata == 64'hDEAD_0000_1234_5678, "R2 forwarded addr/data",
            bank_wdata, 64'hDEAD_0000_1234_5678);
        issue(1'b0, 2'd0, 12'h341, '0);
        chk(csr_en && !csr_we, "R2 csr read no write", {62'd0, csr_en, csr_we}, 64'h2);
        chk(resp_rdata == 64'hC5C5_0000_0000_0341, "R2 csr read data", resp_rdata, 64'hC5C5_0000_0000_0341);
        @(negedge clk);
        chk(resp_ready == 0 && !csr_en, "R1 single ready", {62'd0, resp_ready, csr_en}, 0);
    endtask

    task automatic t_ireg();
        issue(1'b1, 2'd1, 12'd7, 64'h77);
        chk(ireg_en && ireg_we && !npc_we && ireg_idx == 5'd7, "R3 ireg write",
            {56'd0, ireg_idx, ireg_en, ireg_we, npc_we}, {56'd0, 5'd7, 3'b110});
        issue(1'b1, 2'd1, 12'd32, 64'h8000_0000);
        chk(ireg_en && !ireg_we && npc_we, "R3 npc write", {61'd0, ireg_en, ireg_we, npc_we}, 64'h5);
        issue(1'b0, 2'd1, 12'd3, '0);
        chk(resp_rdata == 64'h1E60_0000_0000_0003 && !ireg_we, "R3 ireg read", resp_rdata, 64'h1E60_0000_0000_0003);
    endtask

    task automatic t_none();
        logic [63:0] v; longint unsigned t;
        issue(1'b1, 2'd3, 12'd0, 64'h1);
        chk(resp_ready && !csr_en && !ireg_en && resp_rdata == 0, "R4 region 3 inert",
            resp_rdata, 0);
        @(negedge clk);
        chk(halt_o == 0, "R4 region 3 no halt", 64'(halt_o), 0);
        issue(1'b1, 2'd2, 12'd2, 64'h55);
        chk(!csr_en && !ireg_en, "R4 ctrl no bank enable", {62'd0, csr_en, ireg_en}, 0);
        rd_ctrl(12'h07F, v, t);
        chk(v == 0, "R11 unmapped read", v, 0);
    endtask

    task automatic t_halt();
        logic [63:0] a, b, c, d, h; longint unsigned ta, tb, tc, td;
        rd_ctrl(12'd2, a, ta);
        repeat (4) @(negedge clk);
        rd_ctrl(12'd2, b, tb);
        chk(b - a == 64'(tb - ta), "R6 running clock delta", b - a, 64'(tb - ta));
        issue(1'b1, 2'd2, 12'd0, 64'h1);
        @(negedge clk);
        chk(halt_o == 1, "R5 halt raised", 64'(halt_o), 1);
        rd_ctrl(12'd2, c, tc);
        repeat (5) @(negedge clk);
        rd_ctrl(12'd2, d, td);
        chk(d == c, "R6 clock frozen while halted", d, c);
        rd_ctrl(12'd0, h, tc);
        chk(h == 1, "R5 halt readback", h, 1);
        issue(1'b1, 2'd2, 12'd0, 64'h0);
        @(negedge clk);
        chk(halt_o == 0, "R5 halt released", 64'(halt_o), 0);
    endtask

    task automatic t_retire();
        logic [63:0] v; longint unsigned t;
        retire_i = 1'b1;
        repeat (5) @(negedge clk);
        retire_i = 1'b0;
        rd_ctrl(12'd3, v, t);
        chk(v == 5, "R7 retire count", v, 5);
        issue(1'b1, 2'd2, 12'd3, 64'hFFFF);
        rd_ctrl(12'd3, v, t);
        chk(v == 5, "R7 write ignored", v, 5);
    endtask

    task automatic t_brk();
        logic [63:0] v; longint unsigned t;
        issue(1'b1, 2'd2, 12'd1, 64'h1);
        @(negedge clk);
        chk(brk_mode == 1, "R8 break mode set", 64'(brk_mode), 1);
        rd_ctrl(12'd1, v, t);
        chk(v == 1, "R8 break readback", v, 1);
        issue(1'b1, 2'd2, 12'd1, 64'h0);
        @(negedge clk);
        chk(brk_mode == 0, "R8 break mode cleared", 64'(brk_mode), 0);
    endtask

    task automatic t_inj();
        logic [63:0] v; longint unsigned t;
        issue(1'b1, 2'd2, 12'd4, 64'h8000_1234);
        @(negedge clk);
        chk(inj_valid == 0 && inj_addr == 32'h8000_1234, "R9 address only", 64'(inj_addr), 64'h8000_1234);
        issue(1'b1, 2'd2, 12'd5, 64'hDEAD_BEEF);
        @(negedge clk);
        chk(inj_valid == 1 && inj_instr == 32'hDEAD_BEEF, "R9 armed", 64'(inj_instr), 64'hDEAD_BEEF);
        rd_ctrl(12'd5, v, t);
        chk(v == 64'hDEAD_BEEF, "R9 instr readback", v, 64'hDEAD_BEEF);
        inj_take = 1'b1;
        @(negedge clk);
        inj_take = 1'b0;
        chk(inj_valid == 0, "R9 one-shot clear", 64'(inj_valid), 0);
        chk(inj_addr == 32'h8000_1234 && inj_instr == 32'hDEAD_BEEF, "R9 record kept",
            64'(inj_instr), 64'hDEAD_BEEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_csr();
        t_ireg();
        t_none();
        t_halt();
        t_retire();
        t_brk();
        t_inj();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule